// File: doc/BRIEF.md
# Sequenced Dual Reset Controller

This controller drives two active-low reset lines for a system with a master domain and a slave domain. It takes two "supply good" flags from external comparators, an active-low manual reset request, a mode select and a programmable delay value. The primary reset follows only the master flag and the manual request. The secondary reset follows both flags and the manual request. The two lines are interlocked. The secondary line never releases while the primary line is asserted, and it always asserts before the primary line does.

All inputs are asynchronous and pass through two-flop synchronizers. The manual request also passes through a minimum-width filter. Every timing quantity is a parameter counted in clock cycles: the primary timeout, the fixed secondary timeout, the assertion gap and the manual-reset minimum width. With the default parameters and a 1 MHz clock, the two timeouts come to 200 ms and the gap to 10 µs. In programmable mode the secondary timeout comes from the delay input instead, captured just before the count begins.

Top module: `seq_reset_ctrl`

## Requirements
- R1: While rst_ni is low, and until the timeouts have run after it, both rst1_no and rst2_no are 0 (asserted).
- R2: A master-flag drop asserts rst2_no 3 clock cycles after the input changes (2 synchronizer flops plus the output register).
- R3: When the primary fault begins (master flag low or a valid manual request), rst1_no asserts exactly GAP_CYC cycles after rst2_no asserts. rst1_no never asserts while rst2_no is still released.
- R4: rst1_no releases T1_CYC cycles after the master flag, once synchronized, is high with no manual request. From the input edge this is T1_CYC+2 cycles.
- R5: The secondary flag has no effect on rst1_no, whether the primary reset is asserted, timing or released.
- R6: With the master flag good, a secondary-flag drop asserts only rst2_no, 3 cycles after the input changes.
- R7: The secondary timeout counts only while rst1_no is released and both flags are good. rst2_no is never released while rst1_no is asserted. With sec_mode_prog_i = 0, rst2_no releases T2_FIX_CYC cycles after the count starts.
- R8: With sec_mode_prog_i = 1, the secondary timeout is sec_dly_i cycles, with sec_dly_i sampled in the cycle before the count starts. The values 0 and 1 both give one cycle.
- R9: A man_rst_ni low for at least GLITCH_CYC synchronized cycles asserts rst2_no 3+GLITCH_CYC cycles after the falling input, then rst1_no GAP_CYC cycles later. After man_rst_ni returns high, rst1_no releases T1_CYC+3 cycles later and rst2_no releases its secondary timeout after that.
- R10: A man_rst_ni low pulse shorter than GLITCH_CYC cycles changes neither output.
- R11: A master-flag drop of any length while rst1_no is asserted and timing restarts the primary timeout from zero.
- R12: Once a primary fault starts while rst1_no is released, rst1_no asserts after the gap even if the fault has already cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the logic |
| mst_good_i | input | 1 | Master supply good flag, asynchronous |
| sec_good_i | input | 1 | Secondary supply good flag, asynchronous |
| man_rst_ni | input | 1 | Active-low manual reset request, asynchronous |
| sec_mode_prog_i | input | 1 | 1: secondary timeout taken from sec_dly_i; 0: fixed |
| sec_dly_i | input | DLY_W | Programmable secondary timeout in cycles |
| rst1_no | output | 1 | Primary reset, active low |
| rst2_no | output | 1 | Secondary reset, active low |

## Verification
The assertions check the interlock on every cycle. The primary line only asserts after the secondary line, the secondary line stays asserted whenever the primary is, and each release happens only when its flags were good in the cycle before. They also check that the timeout counters stay below their limit and that the manual filter only fires after a low input. The exact latencies can only be shown by the bench's scenarios: timeout lengths, the gap, the filter threshold, the programmable-delay sampling, timeout restart on a brief drop, and the primary line ignoring the secondary flag. The bench checks each of these as a timed output transition.

// File: rtl/seq_rst_pkg.sv
package seq_rst_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/seq_rst_mr_filt.sv
module seq_rst_mr_filt #(
  parameter int unsigned MIN_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_ni,
  output logic act_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt_q;

  // counts consecutive low cycles, saturates at the minimum width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (mr_ni)                    cnt_q <= '0;
    else if (cnt_q != CW'(MIN_CYC))    cnt_q <= cnt_q + 1'b1;
  end

  assign act_o = (cnt_q == CW'(MIN_CYC));

  p_min_width_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o) |-> $past(!mr_ni));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_ni |=> !act_o);
endmodule

// File: rtl/seq_rst_timer.sv
module seq_rst_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // limit 0 behaves as 1
  assign done_o = run_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_i});

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && lim_i != '0) |-> (cnt_q < lim_i));
endmodule

// File: rtl/seq_reset_ctrl.sv
module seq_reset_ctrl #(
  parameter int unsigned T1_CYC     = 200000,
  parameter int unsigned T2_FIX_CYC = 200000,
  parameter int unsigned GAP_CYC    = 10,
  parameter int unsigned GLITCH_CYC = 5,
  parameter int unsigned DLY_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mst_good_i,
  input  logic             sec_good_i,
  input  logic             man_rst_ni,
  input  logic             sec_mode_prog_i,
  input  logic [DLY_W-1:0] sec_dly_i,
  output logic             rst1_no,
  output logic             rst2_no
);
  import seq_rst_pkg::*;

  localparam int unsigned T1_W  = $clog2(T1_CYC + 1);
  localparam int unsigned T2_W  = max_u($clog2(T2_FIX_CYC + 1), DLY_W);
  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [2:0]  SYNC_RST = 3'b100;

  logic [2:0] async_in, sync_q;
  logic       mst_s, sec_s, mr_s, mr_act;

  assign async_in = {man_rst_ni, sec_good_i, mst_good_i};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    seq_rst_sync #(.STAGES(2), .RST_VAL(SYNC_RST[i])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (async_in[i]),
      .q_o   (sync_q[i])
    );
  end

  assign mst_s = sync_q[0];
  assign sec_s = sync_q[1];
  assign mr_s  = sync_q[2];

  seq_rst_mr_filt #(.MIN_CYC(GLITCH_CYC)) u_mr_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mr_ni (mr_s),
    .act_o (mr_act)
  );

  logic             fault1, fault2, run1, run2, done1, done2;
  logic             rst1_q, rst2_q;
  logic [GAP_W-1:0] pend_q;
  logic [T2_W-1:0]  lim2_q, lim2_sel;

  assign fault1   = !mst_s || mr_act;
  assign fault2   = fault1 || !sec_s;
  assign run1     = rst1_q && !fault1;
  assign run2     = rst2_q && !fault2 && !rst1_q && (pend_q == '0);
  assign lim2_sel = sec_mode_prog_i ? T2_W'(sec_dly_i) : T2_W'(T2_FIX_CYC);

  seq_rst_timer #(.W(T1_W)) u_tmr1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run1),
    .lim_i (T1_W'(T1_CYC)),
    .done_o(done1)
  );

  seq_rst_timer #(.W(T2_W)) u_tmr2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run2),
    .lim_i (lim2_q),
    .done_o(done2)
  );

  // pend_q: committed primary assertion waiting out the gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      rst1_q <= 1'b1;
      rst2_q <= 1'b1;
      lim2_q <= T2_W'(T2_FIX_CYC);
    end else begin
      if (pend_q == '0) begin
        if (fault1 && !rst1_q) pend_q <= GAP_W'(1);
      end else if (pend_q == GAP_W'(GAP_CYC)) begin
        pend_q <= '0;
      end else begin
        pend_q <= pend_q + 1'b1;
      end

      if (pend_q == GAP_W'(GAP_CYC)) rst1_q <= 1'b1;
      else if (done1)                rst1_q <= 1'b0;

      if (fault2 || pend_q != '0) rst2_q <= 1'b1;
      else if (done2)             rst2_q <= 1'b0;

      // limit held while counting, tracks the select otherwise
      if (!run2) lim2_q <= lim2_sel;
    end
  end

  assign rst1_no = !rst1_q;
  assign rst2_no = !rst2_q;

  p_sec_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst1_no) |-> $past(!rst2_no));

  p_sec_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst1_no |-> !rst2_no);

  p_pri_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst1_no) |-> $past(mst_s && !mr_act));

  p_sec_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst2_no) |-> $past(sec_s && mst_s && !mr_act));
endmodule

// File: tb/seq_reset_ctrl_tb.sv
module seq_reset_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T1 = 40;
  localparam int T2 = 25;
  localparam int GAP = 3;
  localparam int GL = 4;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mst_good = 1'b0, sec_good = 1'b0, man_rst_n = 1'b1, mode_prog = 1'b0;
  logic [DW-1:0] sec_dly = 6'd5;
  logic rst1_no, rst2_no;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int    q_which[$];
  int    q_cyc[$];
  logic  q_val[$];
  string q_tag[$];

  seq_reset_ctrl #(
    .T1_CYC(T1), .T2_FIX_CYC(T2), .GAP_CYC(GAP), .GLITCH_CYC(GL), .DLY_W(DW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mst_good_i(mst_good), .sec_good_i(sec_good),
    .man_rst_ni(man_rst_n), .sec_mode_prog_i(mode_prog), .sec_dly_i(sec_dly),
    .rst1_no(rst1_no), .rst2_no(rst2_no)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_ev(input int which, input logic val, input int at, input string tag);
    q_which.push_back(which);
    q_val.push_back(val);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic go_to(input int n);
    @(negedge clk);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic pop_cmp(input int which, input logic val);
    n_vec++;
    if (q_which.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected edge on rst%0d_no cyc %0d actual %b expected no change", which, cyc, val);
    end else begin
      int w = q_which.pop_front();
      logic v = q_val.pop_front();
      int c = q_cyc.pop_front();
      string t = q_tag.pop_front();
      if (w != which || v !== val || c != cyc) begin
        n_bad++;
        $display("FAIL %s actual rst%0d_no=%b at %0d expected rst%0d_no=%b at %0d",
                 t, which, val, cyc, w, v, c);
      end
    end
  endtask

  // monitor: every output edge is matched against the scoreboard
  initial begin
    logic p1 = 1'b0, p2 = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (rst2_no !== p2) begin pop_cmp(2, rst2_no); p2 = rst2_no; end
        if (rst1_no !== p1) begin pop_cmp(1, rst1_no); p1 = rst1_no; end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    go_to(2);
    chk("R1 rst1 in reset", rst1_no, 1'b0);
    chk("R1 rst2 in reset", rst2_no, 1'b0);
    go_to(3); rst_ni = 1'b1;
    go_to(8);
    chk("R1 rst1 before flags", rst1_no, 1'b0);
    chk("R1 rst2 before flags", rst2_no, 1'b0);

    // power-up, fixed secondary timeout
    expect_ev(1, 1'b1, 12 + 2 + T1, "R4 power-up primary release");
    expect_ev(2, 1'b1, 54 + T2, "R7 fixed secondary release");
    go_to(10); sec_good = 1'b1;
    go_to(12); mst_good = 1'b1;

    // secondary-only drop
    expect_ev(2, 1'b0, 103, "R6 secondary drop");
    expect_ev(2, 1'b1, 112 + T2, "R7 secondary re-release");
    go_to(100); sec_good = 1'b0;
    go_to(105); chk("R6 primary unaffected", rst1_no, 1'b1);
    go_to(110); sec_good = 1'b1;

    // programmable mode
    go_to(150); mode_prog = 1'b1; sec_dly = 6'd5;
    expect_ev(2, 1'b0, 163, "R6 drop before prog");
    expect_ev(2, 1'b1, 172 + 5, "R8 programmable 5");
    go_to(160); sec_good = 1'b0;
    go_to(170); sec_good = 1'b1;

    // master drop and sequencing
    expect_ev(2, 1'b0, 203, "R2 secondary on master drop");
    expect_ev(1, 1'b0, 203 + GAP, "R3 primary after gap");
    expect_ev(1, 1'b1, 212 + T1, "R4 primary release");
    expect_ev(2, 1'b1, 252 + 5, "R8 prog after primary");
    go_to(200); mst_good = 1'b0;
    go_to(210); mst_good = 1'b1;

    // programmable value 0
    go_to(260); sec_dly = 6'd0;
    expect_ev(2, 1'b0, 273, "R6 drop before zero");
    expect_ev(2, 1'b1, 283, "R8 programmable 0 is one cycle");
    go_to(270); sec_good = 1'b0;
    go_to(280); sec_good = 1'b1;
    go_to(290); mode_prog = 1'b0;

    // short manual glitch
    go_to(300); man_rst_n = 1'b0;
    go_to(303); man_rst_n = 1'b1;
    go_to(315);
    chk("R10 glitch rst1", rst1_no, 1'b1);
    chk("R10 glitch rst2", rst2_no, 1'b1);

    // held manual reset
    expect_ev(2, 1'b0, 323 + GL, "R9 manual secondary");
    expect_ev(1, 1'b0, 327 + GAP, "R9 manual primary after gap");
    expect_ev(1, 1'b1, 343 + T1, "R9 primary after manual");
    expect_ev(2, 1'b1, 383 + T2, "R9 secondary after manual");
    go_to(320); man_rst_n = 1'b0;
    go_to(340); man_rst_n = 1'b1;

    // manual pulse of exactly the minimum width
    expect_ev(2, 1'b0, 427, "R9 min-width secondary");
    expect_ev(1, 1'b0, 430, "R12 committed primary");
    expect_ev(1, 1'b1, 430 + T1, "R12 primary release");
    expect_ev(2, 1'b1, 470 + T2, "R7 secondary after commit");
    go_to(420); man_rst_n = 1'b0;
    go_to(424); man_rst_n = 1'b1;

    // restart of the primary timeout
    expect_ev(2, 1'b0, 523, "R2 secondary on drop");
    expect_ev(1, 1'b0, 526, "R3 primary after gap");
    expect_ev(1, 1'b1, 553 + T1, "R11 restarted primary");
    expect_ev(2, 1'b1, 593 + T2, "R7 secondary after restart");
    go_to(520); mst_good = 1'b0;
    go_to(530); mst_good = 1'b1;
    go_to(550); mst_good = 1'b0;
    go_to(551); mst_good = 1'b1;

    // secondary flag during primary timeout
    expect_ev(2, 1'b0, 643, "R2 secondary on drop");
    expect_ev(1, 1'b0, 646, "R3 primary after gap");
    expect_ev(1, 1'b1, 692, "R5 primary ignores secondary");
    expect_ev(2, 1'b1, 692 + T2, "R7 secondary waits for primary");
    go_to(640); mst_good = 1'b0;
    go_to(650); mst_good = 1'b1;
    go_to(660); sec_good = 1'b0;
    go_to(665); sec_good = 1'b1;

    // secondary held bad across a primary cycle
    expect_ev(2, 1'b0, 743, "R6 secondary drop");
    expect_ev(1, 1'b0, 756, "R3 primary after gap");
    expect_ev(1, 1'b1, 762 + T1, "R5 primary release with secondary bad");
    expect_ev(2, 1'b1, 822 + T2, "R7 secondary after flag");
    go_to(740); sec_good = 1'b0;
    go_to(750); mst_good = 1'b0;
    go_to(760); mst_good = 1'b1;
    go_to(810); chk("R7 secondary held", rst2_no, 1'b0);
    go_to(820); sec_good = 1'b1;

    go_to(900);
    while (q_which.size() != 0) begin
      int w = q_which.pop_front();
      logic v = q_val.pop_front();
      int c = q_cyc.pop_front();
      string t = q_tag.pop_front();
      n_vec++;
      n_bad++;
      $display("FAIL %s actual no edge expected rst%0d_no=%b at %0d", t, w, v, c);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule